// File: doc/BRIEF.md
# DRAM Channel Bring-Up Sequencer

This block brings one graphics-DRAM channel from reset to a state where normal traffic may start. Once reset is released it waits through a programmable power-up interval. It then asks the PHY to train the command/address path and turns on the word clock. Next it writes eight mode-register values. Last, it asks the PHY for the remaining training. The ready flag rises only after the PHY signals that this last training is complete.

Each PHY step uses a request/done pair. The request stays high until done is sampled and falls in the following cycle. Every wait on the PHY is guarded by a timeout counter. When the counter runs out, the machine goes to a sticky error state in which ready can never rise. A control bit selects PHY-driven training: while that bit is clear, the sequencer parks after power-up without issuing training. A channel-disable input keeps the sequencer in idle for as long as it is held.

Top module: `dram_bringup_seq`

## Requirements
- R1: While reset is asserted, every output (both training requests, wck_en, mrs_valid, mrs_idx, mrs_data, ready, err) is zero.
- R2: While chan_off is high the sequencer stays idle: no training request, wck_en, mode write, ready or err. When chan_off is seen low, the power-up phase starts on the next clock.
- R3: With chan_off low out of reset, ca_train_req first goes high PWRUP_CYCLES+1 clock cycles after reset release.
- R4: If phy_indep_en is low when power-up ends, the sequencer waits with no timeout and no request. ca_train_req rises one cycle after phy_indep_en is seen high.
- R5: Each training request stays high until its done input is sampled high and is low in the next cycle. Done is ignored while the request is low.
- R6: wck_en rises in the same cycle that ca_train_req falls after a successful handshake. It stays high until reset, unless an error occurs.
- R7: Exactly eight mode-register writes follow, with mrs_valid high for one cycle each. mrs_idx counts 0 to 7 in order, and mrs_data for index k equals {1'b0, k[2:0], (8'h35 + 8'h17*k) mod 256}. The first write is one cycle after wck_en rises, and consecutive writes are MR_GAP+1 cycles apart.
- R8: fin_train_req rises in the cycle after the last mode-register write.
- R9: ready rises in the cycle after fin_train_done is sampled during fin_train_req and then stays high until reset.
- R10: If done is not sampled within TIMEOUT_CYCLES cycles of a request being high, the request drops and err rises in the next cycle. A done in the last allowed cycle is still accepted.
- R11: err is sticky until reset. While err is high, ready and wck_en are low and no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_indep_en | input | 1 | Control bit enabling PHY-run training |
| chan_off | input | 1 | Holds the channel disabled in idle |
| ca_train_req | output | 1 | Request for command/address training |
| ca_train_done | input | 1 | PHY completion of command/address training |
| wck_en | output | 1 | Word clock enable |
| fin_train_req | output | 1 | Request for the remaining training steps |
| fin_train_done | input | 1 | PHY training-complete indication |
| mrs_valid | output | 1 | Mode-register write strobe |
| mrs_idx | output | 3 | Mode-register index being written |
| mrs_data | output | 12 | Value written to the mode register |
| ready | output | 1 | Channel ready for normal commands |
| err | output | 1 | Sticky bring-up failure flag |

## Verification
A wrong state or counter appears at the ports as a request, write strobe or ready edge that arrives one or more cycles away from the cycle the requirements predict. Because each edge is timed from the previous handshake, a fault in any phase also shifts every later event. A counter that compares one value too high or too low moves the first request, the write spacing or the error cycle by exactly one clock. An index or table fault shows in the mode-register write that carries it. The timing of every edge is checked while the done latency is swept over the whole timeout window, including the boundary cycle.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_HOLD,
    ST_CATRN,
    ST_WCKON,
    ST_MRS,
    ST_FINTRN,
    ST_READY,
    ST_ERR
  } seq_state_t;

  localparam int MR_COUNT  = 8;
  localparam int MR_IDX_W  = $clog2(MR_COUNT);
  localparam int MR_DATA_W = 12;

  // value programmed into mode register k
  function automatic logic [MR_DATA_W-1:0] mr_value(input logic [MR_IDX_W-1:0] k);
    logic [7:0] low;
    low = 8'h35 + 8'h17 * {{(8-MR_IDX_W){1'b0}}, k};
    return {1'b0, k, low};
  endfunction

endpackage

// File: rtl/step_counter.sv
module step_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mrs_table.sv
module mrs_table
  import bringup_pkg::*;
(
  input  logic [MR_IDX_W-1:0]  idx,
  output logic [MR_DATA_W-1:0] data
);

  always_comb begin
    data = mr_value(idx);
  end

endmodule

// File: rtl/dram_bringup_seq.sv
module dram_bringup_seq
  import bringup_pkg::*;
#(
  parameter int PWRUP_CYCLES   = 200,
  parameter int TIMEOUT_CYCLES = 1000,
  parameter int MR_GAP         = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 phy_indep_en,
  input  logic                 chan_off,
  output logic                 ca_train_req,
  input  logic                 ca_train_done,
  output logic                 wck_en,
  output logic                 fin_train_req,
  input  logic                 fin_train_done,
  output logic                 mrs_valid,
  output logic [MR_IDX_W-1:0]  mrs_idx,
  output logic [MR_DATA_W-1:0] mrs_data,
  output logic                 ready,
  output logic                 err
);

  localparam int MAX_PT = (PWRUP_CYCLES > TIMEOUT_CYCLES) ? PWRUP_CYCLES : TIMEOUT_CYCLES;
  localparam int MAXV   = (MAX_PT > MR_GAP + 1) ? MAX_PT : MR_GAP + 1;
  localparam int CNT_W  = $clog2(MAXV + 1);
  localparam logic [CNT_W-1:0] LIM_P = CNT_W'(PWRUP_CYCLES - 1);
  localparam logic [CNT_W-1:0] LIM_T = CNT_W'(TIMEOUT_CYCLES - 1);
  localparam logic [CNT_W-1:0] LIM_G = CNT_W'(MR_GAP);
  localparam logic [MR_IDX_W-1:0] LAST_IDX = MR_IDX_W'(MR_COUNT - 1);

  seq_state_t state_q, state_n;
  logic [CNT_W-1:0] cnt;
  logic cnt_clr, cnt_en, expired;
  logic [MR_IDX_W-1:0] idx_q;

  assign expired = (cnt == LIM_T);

  // next-state logic
  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:   if (!chan_off) state_n = ST_PWRUP;
      ST_PWRUP:  if (cnt == LIM_P) state_n = phy_indep_en ? ST_CATRN : ST_HOLD;
      ST_HOLD:   if (phy_indep_en) state_n = ST_CATRN;
      ST_CATRN:  if (ca_train_done) state_n = ST_WCKON;
                 else if (expired) state_n = ST_ERR;
      ST_WCKON:  state_n = ST_MRS;
      ST_MRS:    if (mrs_valid && idx_q == LAST_IDX) state_n = ST_FINTRN;
      ST_FINTRN: if (fin_train_done) state_n = ST_READY;
                 else if (expired) state_n = ST_ERR;
      ST_READY:  state_n = ST_READY;
      ST_ERR:    state_n = ST_ERR;
      default:   state_n = ST_ERR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

  // shared phase counter: power-up delay, handshake timeout, write gap
  assign cnt_clr = (state_n != state_q) || ((state_q == ST_MRS) && (cnt == LIM_G));
  assign cnt_en  = (state_q == ST_PWRUP) || (state_q == ST_CATRN) ||
                   (state_q == ST_FINTRN) || (state_q == ST_MRS);

  step_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .cnt   (cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (mrs_valid) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  logic [MR_DATA_W-1:0] table_data;

  mrs_table u_tab (
    .idx  (idx_q),
    .data (table_data)
  );

  assign ca_train_req  = (state_q == ST_CATRN);
  assign fin_train_req = (state_q == ST_FINTRN);
  assign wck_en        = (state_q == ST_WCKON) || (state_q == ST_MRS) ||
                         (state_q == ST_FINTRN) || (state_q == ST_READY);
  assign mrs_valid     = (state_q == ST_MRS) && (cnt == '0);
  assign mrs_idx       = mrs_valid ? idx_q : '0;
  assign mrs_data      = mrs_valid ? table_data : '0;
  assign ready         = (state_q == ST_READY);
  assign err           = (state_q == ST_ERR);

  // R5
  ca_req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ca_train_req && ca_train_done) |=> !ca_train_req);

  // R5
  fin_req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_train_req && fin_train_done) |=> !fin_train_req);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && chan_off) |=> (state_q == ST_IDLE));

  // R10
  ca_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ca_train_req && !ca_train_done && expired) |=> err);

  // R9
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && !ready && !wck_en));

  // R6
  ready_wck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> wck_en);

  // R7
  mrs_wck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_valid |-> (wck_en && !ca_train_req && !fin_train_req));

endmodule

// File: tb/sim_dram_bringup_seq.sv
`timescale 1ns/1ps
module sim_dram_bringup_seq;

  localparam int P = 6;
  localparam int T = 8;
  localparam int G = 2;
  localparam int RUNLEN = 240;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phy_indep_en = 1'b1;
  logic chan_off = 1'b0;
  logic ca_train_done = 1'b0;
  logic fin_train_done = 1'b0;
  logic ca_train_req, wck_en, fin_train_req, mrs_valid, ready, err;
  logic [2:0] mrs_idx;
  logic [11:0] mrs_data;

  always #10 clk = ~clk;

  dram_bringup_seq #(.PWRUP_CYCLES(P), .TIMEOUT_CYCLES(T), .MR_GAP(G)) u0 (
    .clk(clk), .rst_n(rst_n), .phy_indep_en(phy_indep_en), .chan_off(chan_off),
    .ca_train_req(ca_train_req), .ca_train_done(ca_train_done), .wck_en(wck_en),
    .fin_train_req(fin_train_req), .fin_train_done(fin_train_done),
    .mrs_valid(mrs_valid), .mrs_idx(mrs_idx), .mrs_data(mrs_data),
    .ready(ready), .err(err)
  );

  int nchk = 0;
  int nfail = 0;
  int first_ca, first_fin, first_wck, first_rdy, first_err;
  int ca_hi, fin_hi, rdy_hi, err_hi, nw, both, wck_end;
  int w_cyc[8];
  int w_idx[8];
  int w_dat[8];

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mr_exp(input int k);
    return (k << 8) | ((53 + 23 * k) & 255);
  endfunction

  // off_until: cycle chan_off is dropped (0 = never raised); hold: extra cycles phy_indep_en low
  // dca / dfin: cycles of request before done (0 = never answered)
  task automatic run(input int off_until, input int hold, input int dca, input int dfin);
    chan_off = (off_until > 0);
    phy_indep_en = (hold == 0);
    ca_train_done = 1'b0;
    fin_train_done = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1", {ca_train_req, fin_train_req, wck_en, mrs_valid, mrs_idx, mrs_data, ready, err}, 0);
    rst_n = 1'b1;
    first_ca = -1; first_fin = -1; first_wck = -1; first_rdy = -1; first_err = -1;
    ca_hi = 0; fin_hi = 0; rdy_hi = 0; err_hi = 0; nw = 0; both = 0; wck_end = 0;
    for (int c = 1; c <= RUNLEN; c++) begin
      @(negedge clk);
      if (off_until > 0 && c == off_until) chan_off = 1'b0;
      if (hold > 0 && c == P + 1 + hold) phy_indep_en = 1'b1;
      if (ca_train_req) begin
        if (first_ca < 0) first_ca = c;
        ca_hi++;
        ca_train_done = (dca > 0 && ca_hi == dca);
      end else begin
        ca_train_done = 1'b0;
      end
      if (fin_train_req) begin
        if (first_fin < 0) first_fin = c;
        fin_hi++;
        fin_train_done = (dfin > 0 && fin_hi == dfin);
      end else begin
        fin_train_done = 1'b0;
      end
      if (wck_en && first_wck < 0) first_wck = c;
      if (mrs_valid) begin
        if (nw < 8) begin
          w_cyc[nw] = c; w_idx[nw] = int'(mrs_idx); w_dat[nw] = int'(mrs_data);
        end
        nw++;
      end
      if (ready) begin
        if (first_rdy < 0) first_rdy = c;
        rdy_hi++;
      end
      if (err) begin
        if (first_err < 0) first_err = c;
        err_hi++;
      end
      if (ready && err) both++;
      if (c == RUNLEN) wck_end = int'(wck_en);
    end
  endtask

  task automatic check_success(input int base, input int dca, input int dfin);
    chk("R3", first_ca, base);
    chk("R5 ca", ca_hi, dca);
    chk("R6", first_wck, first_ca + dca);
    chk("R6 end", wck_end, 1);
    chk("R7 count", nw, 8);
    for (int k = 0; k < 8; k++) begin
      chk("R7 idx", w_idx[k], k);
      chk("R7 data", w_dat[k], mr_exp(k));
      chk("R7 cycle", w_cyc[k], first_wck + 1 + k * (G + 1));
    end
    chk("R8", first_fin, w_cyc[7] + 1);
    chk("R5 fin", fin_hi, dfin);
    chk("R9", first_rdy, first_fin + dfin);
    chk("R9 sticky", rdy_hi, RUNLEN - first_rdy + 1);
    chk("R11 none", first_err, -1);
  endtask

  initial begin
    // sweep done latency over the full timeout window (R10 boundary at d == T)
    for (int d = 1; d <= T; d++) begin
      run(0, 0, d, T + 1 - d);
      check_success(P + 1, d, T + 1 - d);
    end
    // R2: channel held off for the whole run
    run(RUNLEN + 50, 0, 2, 2);
    chk("R2 req", ca_hi + fin_hi, 0);
    chk("R2 wck", first_wck, -1);
    chk("R2 mrs", nw, 0);
    chk("R2 ready", first_rdy, -1);
    chk("R2 err", first_err, -1);
    // R2: channel released later
    run(30, 0, 3, 3);
    check_success(30 + 1 + P, 3, 3);
    // R4: training bit held low past power-up, longer than the timeout
    run(0, 20, 2, 4);
    chk("R4 noerr", first_err, -1);
    check_success(P + 2 + 20, 2, 4);
    // R10 / R11: command/address training never completes
    run(0, 0, 0, 1);
    chk("R10 ca hi", ca_hi, T);
    chk("R10 ca err", first_err, first_ca + T);
    chk("R11 sticky", err_hi, RUNLEN - first_err + 1);
    chk("R11 wck", first_wck, -1);
    chk("R11 ready", first_rdy, -1);
    // R10 / R11: final training never completes
    run(0, 0, 2, 0);
    chk("R10 fin hi", fin_hi, T);
    chk("R10 fin err", first_err, first_fin + T);
    chk("R11 wck end", wck_end, 0);
    chk("R11 ready", first_rdy, -1);
    chk("R11 both", both, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule